// File: doc/BRIEF.md
# Ling Pseudo-Carry Adder

This block adds two unsigned operands and a carry-in without any arithmetic operator in its datapath. Rather than forming the usual group-generate signal, its carry chain evaluates a Ling pseudo-carry `H`. The terms of `H` need smaller fan-in than the matching generate terms. Each real carry is then rebuilt as the product of a per-bit transmit signal and `H`.

The datapath has three stages. First, every bit produces a generate (`x AND y`), a transmit (`x OR y`) and a half-sum (`x XOR y`), and the carry-in is merged into the generate of bit 0. Next, the pseudo-carry is evaluated in pairs of bits. Each pair forms `G(2k+1) OR G(2k)`, and that value is combined with the pseudo-carry of the lower pairs through the shifted transmit product `T(2k)·T(2k-1)`. Finally, bit i receives the carry `T(i-1)·H(i-1:0)`, its sum is the half-sum XOR that carry, and the carry out of the top bit is `T(W-1)·H(W-1:0)`.

The block is purely combinational and is meant to sit between registers of the surrounding pipeline. It can also be used on its own as a drop-in adder.

Top module: `ling_adder`

## Requirements
- R1: `{cout, sum}` equals the unsigned sum `opa + opb + cin` for every input combination at the default width of 16 bits.
- R2: `cout` is 1 exactly when the true sum exceeds 16 bits. For example, `opa = 16'hFFFF`, `opb = 16'h0001`, `cin = 0` gives `cout = 1` and `sum = 0`.
- R3: The carry into bit 4, observed at the ports as `sum[4] ^ opa[4] ^ opb[4]`, equals `T3·(G3 + G2 + T2·G1 + T2·T1·G0')`. Here `Gi = opa[i]&opb[i]`, `Ti = opa[i]|opb[i]`, and `G0' = G0 + T0·cin`.
- R4: With both operands zero, `sum` equals `{15'b0, cin}` and `cout` is 0.
- R5: When every bit propagates (`opa ^ opb` all ones), `sum` equals the inverse of `{16{cin}}` and `cout` equals `cin`.
- R6: A carry generated at bit 0 ripples through a fully propagating upper field. For example, `opa = 16'h0001`, `opb = 16'hFFFF`, `cin = 0` gives `sum = 0` and `cout = 1`.
- R7: Exchanging `opa` and `opb` leaves `{cout, sum}` unchanged.
- R8: The outputs respond to an input change in the same cycle; no register lies between any input and any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa  | input  | 16 | First operand |
| opb  | input  | 16 | Second operand |
| cin  | input  | 1  | Carry into bit 0 |
| sum  | output | 16 | Sum bits |
| cout | output | 1  | Carry out of bit 15 |

## Verification
Every result of this block is due in the same cycle as its stimulus, with zero register stages on any path. The bench therefore applies operands just after a rising clock edge and samples `sum` and `cout` at the following falling edge, half a period later. Because nothing is held over from earlier vectors, each check depends only on the inputs driven in that cycle. The bench computes the expected values itself with a plain 17-bit addition.

// File: rtl/ling_pkg.sv
package ling_pkg;
   // number of bit positions combined per pseudo-carry group
   localparam int unsigned LING_GRP_W = 2;
   // smallest operand width the pair organisation supports
   localparam int unsigned LING_MIN_W = 2;
endpackage

// File: rtl/ling_bitsig.sv
module ling_bitsig #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] gen,
   output logic [W-1:0] xmt,
   output logic [W-1:0] hsum
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign xmt[i]  = x[i] | y[i];
      assign hsum[i] = x[i] ^ y[i];
      if (i == 0) begin : g_fold
         // carry-in merged into the generate of the lowest position
         assign gen[i] = (x[i] & y[i]) | (xmt[i] & cin);
      end else begin : g_plain
         assign gen[i] = x[i] & y[i];
      end
   end
endmodule

// File: rtl/ling_hchain.sv
module ling_hchain
   import ling_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] gen,
   input  logic [W-1:0] xmt,
   output logic [W-1:0] hps
);
   localparam int unsigned NPAIR = W / LING_GRP_W;

   logic [NPAIR-1:0] hpair;

   for (genvar k = 0; k < NPAIR; k++) begin : g_pair
      localparam int unsigned LO = LING_GRP_W * k;
      localparam int unsigned HI = LO + 1;
      // pair-local pseudo-carry: either bit generating is enough
      assign hpair[k] = gen[HI] | gen[LO];
      if (k == 0) begin : g_first
         assign hps[LO] = gen[LO];
         assign hps[HI] = hpair[k];
      end else begin : g_next
         // shifted transmit product T(LO)*T(LO-1) links to the lower pairs
         assign hps[LO] = gen[LO] | (xmt[LO-1] & hps[LO-1]);
         assign hps[HI] = hpair[k] | (xmt[LO] & xmt[LO-1] & hps[LO-1]);
      end
   end
endmodule

// File: rtl/ling_carrysum.sv
module ling_carrysum #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] hsum,
   input  logic [W-1:0] xmt,
   input  logic [W-1:0] hps,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W:0] cy;

   assign cy[0] = cin;
   for (genvar i = 0; i < W; i++) begin : g_cy
      // real carry rebuilt from transmit and pseudo-carry
      assign cy[i+1] = xmt[i] & hps[i];
      assign sum[i]  = hsum[i] ^ cy[i];
   end
   assign cout = cy[W];
endmodule

// File: rtl/ling_adder.sv
module ling_adder
   import ling_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   if (WIDTH < LING_MIN_W || (WIDTH % LING_GRP_W) != 0) begin : g_bad_width
      $error("ling_adder: WIDTH must be a multiple of the group width");
   end

   logic [WIDTH-1:0] gen_w;
   logic [WIDTH-1:0] xmt_w;
   logic [WIDTH-1:0] hsum_w;
   logic [WIDTH-1:0] h_w;

   ling_bitsig #(.W(WIDTH)) bitsig_i (
      .x    (opa),
      .y    (opb),
      .cin  (cin),
      .gen  (gen_w),
      .xmt  (xmt_w),
      .hsum (hsum_w)
   );

   ling_hchain #(.W(WIDTH)) hchain_i (
      .gen (gen_w),
      .xmt (xmt_w),
      .hps (h_w)
   );

   ling_carrysum #(.W(WIDTH)) carrysum_i (
      .hsum (hsum_w),
      .xmt  (xmt_w),
      .hps  (h_w),
      .cin  (cin),
      .sum  (sum),
      .cout (cout)
   );
endmodule

// File: rtl/ling_adder_chk.sv
module ling_adder_chk #(
   parameter int unsigned WIDTH = 16
) (
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic             c_i,
   input logic [WIDTH-1:0] s_i,
   input logic             co_i,
   input logic             h3_i
);
   logic [WIDTH:0] ref_w;
   logic           g0f;
   logic           hexp;

   assign ref_w = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c_i};
   assign g0f   = (a_i[0] & b_i[0]) | ((a_i[0] | b_i[0]) & c_i);
   assign hexp  = (a_i[3] & b_i[3]) | (a_i[2] & b_i[2])
                | ((a_i[2] | b_i[2]) & a_i[1] & b_i[1])
                | ((a_i[2] | b_i[2]) & (a_i[1] | b_i[1]) & g0f);

   always_comb begin
      if (!$isunknown({a_i, b_i, c_i})) begin
         // R1
         sum_match_chk: assert ({co_i, s_i} == ref_w)
            else $error("sum mismatch");
         // R3
         hexp_match_chk: assert (h3_i == hexp)
            else $error("pseudo-carry H3:0 differs from expanded form");
         // R4
         zero_ops_chk: assert (!((a_i == '0) && (b_i == '0))
                               || ({co_i, s_i} == {{WIDTH{1'b0}}, c_i}))
            else $error("zero operands");
         // R5
         full_prop_chk: assert (!((a_i ^ b_i) == '1) || (co_i == c_i))
            else $error("full propagate carry-out");
      end
   end
endmodule

bind ling_adder ling_adder_chk #(.WIDTH(WIDTH)) chk_i (
   .a_i  (opa),
   .b_i  (opb),
   .c_i  (cin),
   .s_i  (sum),
   .co_i (cout),
   .h3_i (h_w[3])
);

// File: tb/ling_adder_tb_top.sv
`timescale 1ns/1ps
module ling_adder_tb_top;
   localparam int unsigned W     = 16;
   localparam int unsigned NTAB  = 12;
   localparam int unsigned NRAND = 10000;

   // {opa, opb, cin}
   localparam logic [2*W:0] TAB [NTAB] = '{
      {16'h0000, 16'h0000, 1'b0},
      {16'h0000, 16'h0000, 1'b1},
      {16'hFFFF, 16'hFFFF, 1'b1},
      {16'hFFFF, 16'h0000, 1'b1},
      {16'hAAAA, 16'h5555, 1'b0},
      {16'hAAAA, 16'h5555, 1'b1},
      {16'h8000, 16'h8000, 1'b0},
      {16'h1234, 16'hEDCB, 1'b1},
      {16'h7FFF, 16'h0001, 1'b0},
      {16'h000F, 16'h0001, 1'b0},
      {16'hF0F0, 16'h0F0F, 1'b1},
      {16'hC3A5, 16'h5A3C, 1'b0}
   };

   logic         clk = 1'b0;
   logic [W-1:0] opa = '0;
   logic [W-1:0] opb = '0;
   logic         cin = 1'b0;
   logic [W-1:0] sum;
   logic         cout;

   int unsigned n_run  = 0;
   int unsigned n_fail = 0;
   bit          done   = 1'b0;

   always #4 clk = ~clk;

   ling_adder #(.WIDTH(W)) dut_i (
      .opa  (opa),
      .opb  (opb),
      .cin  (cin),
      .sum  (sum),
      .cout (cout)
   );

   task automatic expect17(input string rq, input logic [W:0] act, input logic [W:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", rq, act, exp);
      end
   endtask

   // drive after a rising edge, sample at the falling edge (same cycle)
   task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic tc);
      @(posedge clk);
      opa = ta;
      opb = tb;
      cin = tc;
      @(negedge clk);
   endtask

   function automatic logic [W:0] ref_add(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic tc);
      return {1'b0, ta} + {1'b0, tb} + {{W{1'b0}}, tc};
   endfunction

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W:0]   r1;
      logic [W-1:0] ra, rb;
      logic         rc, c4, g0f, t1, t2, t3;

      // R8: zero inputs settle within the first cycle
      @(negedge clk);
      expect17("R8 zero state", {cout, sum}, '0);

      for (int i = 0; i < NTAB; i++) begin
         apply(TAB[i][2*W:W+1], TAB[i][W:1], TAB[i][0]);
         expect17("R1 table", {cout, sum}, ref_add(TAB[i][2*W:W+1], TAB[i][W:1], TAB[i][0]));
      end

      // R4: zero operands pass cin through
      apply('0, '0, 1'b1);
      expect17("R4 zero cin=1", {cout, sum}, 17'h00001);
      apply('0, '0, 1'b0);
      expect17("R4 zero cin=0", {cout, sum}, 17'h00000);

      // R5: full propagate
      apply(16'h00FF, 16'hFF00, 1'b1);
      expect17("R5 prop cin=1", {cout, sum}, 17'h10000);
      apply(16'h3C3C, 16'hC3C3, 1'b0);
      expect17("R5 prop cin=0", {cout, sum}, 17'h0FFFF);

      // R6: generate at bit 0 ripples to the top
      apply(16'h0001, 16'hFFFF, 1'b0);
      expect17("R6 ripple", {cout, sum}, 17'h10000);

      // R2: overflow boundary
      apply(16'hFFFF, 16'h0001, 1'b0);
      expect17("R2 overflow", {cout, sum}, 17'h10000);
      apply(16'hFFFE, 16'h0001, 1'b0);
      expect17("R2 no overflow", {cout, sum}, 17'h0FFFF);

      // R7: commutativity
      apply(16'h9A3F, 16'h0761, 1'b1);
      r1 = {cout, sum};
      apply(16'h0761, 16'h9A3F, 1'b1);
      expect17("R7 swap", {cout, sum}, r1);

      // R1 and R3 over random vectors
      for (int i = 0; i < NRAND; i++) begin
         ra = W'($urandom);
         rb = W'($urandom);
         rc = 1'($urandom);
         apply(ra, rb, rc);
         expect17("R1 random", {cout, sum}, ref_add(ra, rb, rc));
         if (i < 64) begin
            g0f = (ra[0] & rb[0]) | ((ra[0] | rb[0]) & rc);
            t1 = ra[1] | rb[1];
            t2 = ra[2] | rb[2];
            t3 = ra[3] | rb[3];
            c4 = t3 & ((ra[3] & rb[3]) | (ra[2] & rb[2]) | (t2 & ra[1] & rb[1]) | (t2 & t1 & g0f));
            expect17("R3 carry4", {16'b0, sum[4] ^ ra[4] ^ rb[4]}, {16'b0, c4});
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule